// File: doc/BRIEF.md
# Interlaced Raster Sync Generator

This block produces the timing signals for a 625-line interlaced television raster from one pixel-rate clock. A counter splits each line into two halves of `HALF_CLKS` clocks, a toggle marks which half of the line is current, and a half-line counter of 1250 steps spans one frame. Composite sync, a separate line-rate sync, field blanking and a second-field flag are all decoded from these counters. Nothing else is needed: the vertical equalising and broad pulses fall on half-line boundaries, and the field parity is simply which half of the 1250-step count the raster is in.

Each pulse is a set/clear flip-flop that is set when the in-half clock count equals a common start position and cleared when it reaches the start plus a width. The start position and three widths (line sync, equalising, broad) sit in four write-only registers reached through a small control bus in the pixel clock domain. A write lands in a holding register at once but only reaches the pulse logic at the next frame start, so a field is never drawn with mixed timing.

Top module: `tv_sync_gen`

## Requirements
- R1: While `rst_n` is low, `csync`, `hsync`, `vblank` and `field` are all 0. After release, the counters start at half line 0, clock 0.
- R2: The counters advance one clock position per clock. Each output seen after a clock edge describes the position the counters held just before that edge. A half line lasts `HALF_CLKS` clocks and a frame lasts 1250 half lines.
- R3: `field` is 1 for half lines 625 to 1249 and 0 for half lines 0 to 624.
- R4: `vblank` is 1 for half lines 0 to 49 and 625 to 674, and 0 elsewhere.
- R5: In half lines 0 to 4 and 625 to 629, `csync` carries a broad pulse whose width is taken from register 3.
- R6: In half lines 5 to 9, 620 to 624, 630 to 634 and 1245 to 1249, `csync` carries an equalising pulse whose width is taken from register 2.
- R7: In every other half line, `csync` carries a line sync pulse (width from register 1) only when the half-line number is even, and stays low when it is odd. `hsync` carries the line sync pulse in every even half line, whatever the region.
- R8: Every pulse starts at the clock position held in register 0, so changing that one value moves all pulses together.
- R9: A pulse is high for clock positions p with start <= p < start + width and p < `HALF_CLKS` - 1. A width of 0 gives no pulse, and no pulse runs into the next half line.
- R10: A write happens on each clock with `ctl_sel` high. `ctl_addr` picks the register: 0 start position, 1 line sync width, 2 equalising width, 3 broad width. `ctl_wdata` is the value.
- R11: A written value governs the pulses only from the first clock of the next frame (half line 0, position 0). Until then the previous value stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sel | input | 1 | Register write strobe |
| ctl_addr | input | 2 | Register select |
| ctl_wdata | input | HW = ceil(log2(HALF_CLKS+1)) | Register write value |
| csync | output | 1 | Composite sync, active high |
| hsync | output | 1 | Line-rate sync, active high |
| vblank | output | 1 | Field blanking, active high |
| field | output | 1 | High during the second field |

## Verification
The bench models every clock position of several whole frames and targets the places where counter decoding tends to slip by one: the edges of the broad and equalising ranges around half lines 625 and 1249, the odd half lines that must stay quiet, and the frame wrap. A design off by one half line would shift `field` or `vblank`, or put a line pulse into an equalising slot. Pulses of zero width and pulses wider than the half line are forced on purpose, so a flip-flop with the wrong set/clear priority would emit a stray one-clock pulse or run past the half-line boundary. Register writes are made in the middle of a frame, so logic that applies them at once would tear that field and show up as a mismatch before the next frame start.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int unsigned HLW = 11;
  localparam logic [HLW-1:0] HL_LAST   = 11'd1249;
  localparam logic [HLW-1:0] HL_FIELD2 = 11'd625;
  localparam logic [HLW-1:0] HL_VBL    = 11'd50;
  localparam int unsigned CFG_OFF   = 0;
  localparam int unsigned CFG_LINE  = 1;
  localparam int unsigned CFG_EQ    = 2;
  localparam int unsigned CFG_BROAD = 3;
  localparam int unsigned CFG_N     = 4;

  typedef enum logic [1:0] {PK_NONE = 2'd0, PK_LINE = 2'd1, PK_EQ = 2'd2, PK_BROAD = 2'd3} pulse_kind_e;

  // Both fields share one pattern when measured from their own first half line.
  function automatic pulse_kind_e classify(input logic [HLW-1:0] hl, input logic odd_half);
    logic [HLW-1:0] rel;
    rel = (hl >= HL_FIELD2) ? hl - HL_FIELD2 : hl;
    if (rel < 11'd5)                          return PK_BROAD;
    else if (rel < 11'd10 || rel >= 11'd620)  return PK_EQ;
    else if (!odd_half)                       return PK_LINE;
    else                                      return PK_NONE;
  endfunction
endpackage

// File: rtl/tvs_timebase.sv
module tvs_timebase #(
  parameter int unsigned HALF_CLKS = 288,
  parameter int unsigned HW = 9
) (
  input  logic clk,
  input  logic rst_n,
  output logic [HW-1:0] hcnt,
  output logic [tvs_pkg::HLW-1:0] hl,
  output logic odd_half,
  output logic half_end,
  output logic frame_end
);
  import tvs_pkg::*;
  localparam logic [HW-1:0] HLAST = HW'(HALF_CLKS - 1);

  logic [HW-1:0]  hcnt_d;
  logic [HLW-1:0] hl_d;
  logic           odd_d;

  always_comb begin
    half_end  = (hcnt == HLAST);
    frame_end = half_end && (hl == HL_LAST);
    hcnt_d    = half_end ? '0 : hcnt + 1'b1;
    hl_d      = frame_end ? '0 : hl + 11'd1;
    odd_d     = ~odd_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      hl       <= '0;
      odd_half <= 1'b0;
    end else begin
      hcnt <= hcnt_d;
      if (half_end) begin
        hl       <= hl_d;
        odd_half <= odd_d;
      end
    end
  end
endmodule

// File: rtl/tvs_regs.sv
module tvs_regs #(
  parameter int unsigned HW = 9,
  parameter int unsigned DEF_OFF = 8,
  parameter int unsigned DEF_LINE = 21,
  parameter int unsigned DEF_EQ = 11,
  parameter int unsigned DEF_BROAD = 123
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic [1:0] addr,
  input  logic [HW-1:0] wdata,
  input  logic frame_end,
  output logic [tvs_pkg::CFG_N-1:0][HW-1:0] cfg_live
);
  import tvs_pkg::*;
  localparam logic [CFG_N-1:0][HW-1:0] DEFS =
    {HW'(DEF_BROAD), HW'(DEF_EQ), HW'(DEF_LINE), HW'(DEF_OFF)};

  logic [CFG_N-1:0][HW-1:0] shadow;

  for (genvar i = 0; i < CFG_N; i++) begin : g_reg
    logic          wr_en;
    logic [HW-1:0] shadow_d;
    logic [HW-1:0] live_d;

    always_comb begin
      wr_en    = sel && (addr == 2'(i));
      shadow_d = wr_en ? wdata : shadow[i];
      live_d   = frame_end ? shadow[i] : cfg_live[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i]   <= DEFS[i];
        cfg_live[i] <= DEFS[i];
      end else begin
        shadow[i]   <= shadow_d;
        cfg_live[i] <= live_d;
      end
    end
  end
endmodule

// File: rtl/tvs_pulse.sv
module tvs_pulse #(
  parameter int unsigned HALF_CLKS = 288,
  parameter int unsigned HW = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic [HW-1:0] hcnt,
  input  logic [HW-1:0] start,
  input  logic [HW-1:0] width,
  output logic q
);
  localparam logic [HW-1:0] HLAST = HW'(HALF_CLKS - 1);

  logic [HW:0] stop;
  logic set_c, clr_c, q_d;

  // Set/clear flop: clear wins, and the last clock of a half line always clears.
  always_comb begin
    stop  = {1'b0, start} + {1'b0, width};
    set_c = arm && (hcnt == start);
    clr_c = ({1'b0, hcnt} == stop) || (hcnt == HLAST);
    if (clr_c)      q_d = 1'b0;
    else if (set_c) q_d = 1'b1;
    else            q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/tv_sync_gen.sv
module tv_sync_gen #(
  parameter int unsigned HALF_CLKS = 288,
  parameter int unsigned DEF_OFF = 8,
  parameter int unsigned DEF_LINE = 21,
  parameter int unsigned DEF_EQ = 11,
  parameter int unsigned DEF_BROAD = 123,
  localparam int unsigned HW = $clog2(HALF_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_sel,
  input  logic [1:0] ctl_addr,
  input  logic [HW-1:0] ctl_wdata,
  output logic csync,
  output logic hsync,
  output logic vblank,
  output logic field
);
  import tvs_pkg::*;

  logic [HW-1:0]  hcnt;
  logic [HLW-1:0] hl;
  logic           odd_half, half_end, frame_end;
  logic [CFG_N-1:0][HW-1:0] cfg_live;
  pulse_kind_e    kind;
  logic [HW-1:0]  cs_width;
  logic           vblank_d, field_d;

  tvs_timebase #(.HALF_CLKS(HALF_CLKS), .HW(HW)) u_tb (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .hl(hl), .odd_half(odd_half),
    .half_end(half_end), .frame_end(frame_end));

  tvs_regs #(.HW(HW), .DEF_OFF(DEF_OFF), .DEF_LINE(DEF_LINE), .DEF_EQ(DEF_EQ),
             .DEF_BROAD(DEF_BROAD)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(ctl_sel), .addr(ctl_addr), .wdata(ctl_wdata),
    .frame_end(frame_end), .cfg_live(cfg_live));

  always_comb begin
    kind = classify(hl, odd_half);
    case (kind)
      PK_BROAD: cs_width = cfg_live[CFG_BROAD];
      PK_EQ:    cs_width = cfg_live[CFG_EQ];
      default:  cs_width = cfg_live[CFG_LINE];
    endcase
    field_d  = (hl >= HL_FIELD2);
    vblank_d = (hl < HL_VBL) || (field_d && (hl < HL_FIELD2 + HL_VBL));
  end

  tvs_pulse #(.HALF_CLKS(HALF_CLKS), .HW(HW)) u_cs (
    .clk(clk), .rst_n(rst_n), .arm(kind != PK_NONE), .hcnt(hcnt),
    .start(cfg_live[CFG_OFF]), .width(cs_width), .q(csync));

  tvs_pulse #(.HALF_CLKS(HALF_CLKS), .HW(HW)) u_hs (
    .clk(clk), .rst_n(rst_n), .arm(!odd_half), .hcnt(hcnt),
    .start(cfg_live[CFG_OFF]), .width(cfg_live[CFG_LINE]), .q(hsync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vblank <= 1'b0;
      field  <= 1'b0;
    end else begin
      vblank <= vblank_d;
      field  <= field_d;
    end
  end
endmodule

// File: rtl/tv_sync_chk.sv
module tv_sync_chk #(
  parameter int unsigned HALF_CLKS = 288,
  parameter int unsigned HW = 9
) (
  input logic clk,
  input logic rst_n,
  input logic [HW-1:0] hcnt,
  input logic [10:0] hl,
  input logic odd_half,
  input logic frame_end,
  input logic [4*HW-1:0] cfg_flat,
  input logic csync,
  input logic hsync,
  input logic vblank,
  input logic field
);
  localparam logic [HW-1:0] HLAST = HW'(HALF_CLKS - 1);

  AST_HALF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HLAST) |=> (hcnt == '0)); // R2
  AST_HL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HLAST) |=> $stable(hl)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hl == 11'd1249 && hcnt == HLAST) |=> (hl == 11'd0)); // R2
  AST_FIELD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field) |-> (hl == 11'd625)); // R3
  AST_FIELD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field) |-> (hl == 11'd0)); // R3
  AST_BLANK_AT_FIELD2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field) |-> vblank); // R4
  AST_ODD_NO_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && hcnt != '0) |-> !odd_half); // R7
  AST_HALF_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == '0) |-> (!csync && !hsync)); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_flat)); // R11
endmodule

bind tv_sync_gen tv_sync_chk #(.HALF_CLKS(HALF_CLKS), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .hl(hl), .odd_half(odd_half),
  .frame_end(frame_end), .cfg_flat(cfg_live), .csync(csync), .hsync(hsync),
  .vblank(vblank), .field(field));

// File: tb/tb_tv_sync_gen.sv
module tb_tv_sync_gen;
  localparam int H = 16;
  localparam int W = $clog2(H + 1);
  localparam int FRAME = 1250 * H;
  localparam int NFR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_sel = 1'b0;
  logic [1:0] ctl_addr = '0;
  logic [W-1:0] ctl_wdata = '0;
  logic csync, hsync, vblank, field;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  int pend[4], live[4], nv[4];
  logic e_cs, e_hs, e_vb, e_fd;
  string e_cs_tag;

  always #4 clk = ~clk;

  tv_sync_gen #(.HALF_CLKS(H), .DEF_OFF(1), .DEF_LINE(3), .DEF_EQ(1), .DEF_BROAD(12)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .csync(csync), .hsync(hsync), .vblank(vblank), .field(field));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // 0 none, 1 line, 2 equalising, 3 broad
  function automatic int kind_of(input int hl);
    int r = (hl >= 625) ? hl - 625 : hl;
    if (r <= 4) return 3;
    if (r <= 9 || r >= 620) return 2;
    if (hl % 2 == 0) return 1;
    return 0;
  endfunction

  function automatic logic in_pulse(input int k, input int off, input int w);
    return (k >= off) && (k < off + w) && (k < H - 1);
  endfunction

  function automatic string ftag(input int f);
    case (f)
      0: return "R11";
      1: return "R10";
      2: return "R9";
      3: return "R10";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int mk = 0, mhl = 0;
    int kd, f, ph;
    void'($urandom(32'd4711));
    // R1: outputs idle while reset is held
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 csync", csync, 1'b0); chk("R1 hsync", hsync, 1'b0);
      chk("R1 vblank", vblank, 1'b0); chk("R1 field", field, 1'b0);
    end
    rst_n = 1'b1;
    pend = '{1, 3, 1, 12};
    live = pend;
    e_cs = 0; e_hs = 0; e_vb = 0; e_fd = 0; e_cs_tag = "R1";
    for (int c = 0; c < NFR * FRAME + 2; c++) begin
      cyc = c;
      if (c == 0) begin
        chk("R1 csync", csync, 1'b0); chk("R1 field", field, 1'b0);
      end else begin
        chk(e_cs_tag, csync, e_cs);
        chk({"R7 hsync ", ftag(f)}, hsync, e_hs);
        chk("R4 vblank", vblank, e_vb);
        chk("R3 field", field, e_fd);
      end
      f = c / FRAME;
      ph = c % FRAME;
      // expected result for the upcoming edge (R2: one clock latency)
      kd = kind_of(mhl);
      e_cs = (kd != 0) && in_pulse(mk, live[0], (kd == 3) ? live[3] : (kd == 2) ? live[2] : live[1]);
      e_cs_tag = (kd == 3) ? "R5 csync" : (kd == 2) ? "R6 csync" : "R7 csync";
      e_cs_tag = {e_cs_tag, " ", ftag(f)};
      e_hs = (mhl % 2 == 0) && in_pulse(mk, live[0], live[1]);
      e_vb = (mhl < 50) || (mhl >= 625 && mhl < 675);
      e_fd = (mhl >= 625);
      if (mk == H - 1 && mhl == 1249) live = pend;   // R11: frame start load
      // mid-frame register writes (R10, directed corners for R8/R9)
      ctl_sel = 1'b0;
      if (ph == 5000) begin
        nv[0] = $urandom % H; nv[1] = $urandom % (H + 1);
        nv[2] = $urandom % (H + 1); nv[3] = $urandom % (H + 1);
        if (f == 0) nv[0] = 3;
        if (f == 2) begin nv[0] = 5; nv[1] = 0; nv[2] = H; nv[3] = H; end
      end
      if (ph >= 5000 && ph < 5004 && f < NFR) begin
        int a = ph - 5000;
        if (f == 1 || f == 2 || f == 3 || a == 0) begin
          ctl_sel = 1'b1; ctl_addr = 2'(a); ctl_wdata = W'(nv[a]);
          pend[a] = nv[a];
        end
      end
      if (mk == H - 1) begin
        mk = 0;
        mhl = (mhl == 1249) ? 0 : mhl + 1;
      end else mk++;
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule